// File: doc/BRIEF.md
# High-Speed Mode Master Code Detector

This block runs next to an I2C target and decides whether the bus is in fast/standard mode or in high-speed mode. It sees the already synchronized SCL and SDA lines as plain samples on the system clock. It finds START and STOP conditions and collects the first byte that follows each START. When that byte is a high-speed master code, the block sets `hs_mode`. The target can use this flag to pick its timing or glitch-filter settings. The flag holds through any number of repeated STARTs and clears only on a STOP.

No device may acknowledge a master code. For that reason the block drives `ack_block` for the whole acknowledge slot of the master code byte, and the target must then keep SDA released. Any other first byte is an ordinary address for the target, and the block takes no action on it.

Operation is a five-state machine:
- **ST_IDLE** waits for a START.
- A START from any state leads to **ST_ADDR**, which collects the first byte.
- A completed master code (while not already in high-speed mode) leads to **ST_CODE_ACK**. This state lasts until the ninth SCL rise.
- That rise leads to **ST_CODE_END**, which lasts until the SCL fall that closes the ninth clock.
- That fall, or any other completed first byte, leads to **ST_PASS**. ST_PASS ignores everything until the next START or STOP.
- A STOP from any state returns the machine to ST_IDLE.

Top module: `hs_code_detect`

## Requirements
- R1: During and right after reset, `hs_mode` and `ack_block` are 0. The line history is taken as idle-high, so reset alone produces no condition.
- R2: A START is SDA going 1 to 0 while SCL is 1 in two consecutive samples. Only after a START are SDA bits collected, MSB first, on the SCL rising edges. Bits clocked without a START never set `hs_mode`.
- R3: A first byte whose upper five bits are 00001, received while `hs_mode` is 0, sets `hs_mode` one clock after the clock that samples the eighth SCL rise.
- R4: The three low bits of the master code are ignored. All eight values 0x08 to 0x0F set `hs_mode`.
- R5: `ack_block` is 1 from the same cycle that `hs_mode` rises until one clock after the SCL fall that ends the ninth clock of the master code byte. It is 0 at every other time.
- R6: A first byte that is not a master code (for example 0x00, 0x10, 0x50, 0x88) leaves `hs_mode` unchanged and does not raise `ack_block`.
- R7: A repeated START while `hs_mode` is 1 keeps `hs_mode` at 1. The byte that follows it is never taken as a master code, even if it matches 00001xxx, so it raises no `ack_block`.
- R8: A STOP is SDA going 0 to 1 while SCL is 1 in two consecutive samples. In any state, including during the master code acknowledge slot, a STOP clears `hs_mode` and `ack_block` one clock later.
- R9: Only the first byte after a START is examined. A later data byte of the form 00001xxx does not set `hs_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Synchronized SCL sample |
| sda_in | input | 1 | Synchronized SDA sample |
| hs_mode | output | 1 | 1 while the bus is in high-speed mode |
| ack_block | output | 1 | 1 while the target must not acknowledge |

## Verification
Two events can land in the same cycle: a STOP clearing the mode, and the master code acknowledge window still holding `ack_block` high. To provoke this, a master code byte is sent, the ninth SCL clock is raised, and SDA then rises while SCL is still high. The bench expects both outputs to drop together one clock later, with the STOP taking precedence over the pending wait for the ninth SCL fall. The bench also checks that a repeated START inside high-speed mode keeps the flag while it restarts byte capture.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CODE_ACK,
        ST_CODE_END,
        ST_PASS
    } hsd_state_e;

    localparam int BYTE_W = 8;
    localparam int TAG_W  = 5;
    localparam logic [TAG_W-1:0] HS_TAG = 5'b00001;
endpackage

// File: rtl/hsd_cond_det.sv
module hsd_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic start_p,
    output logic stop_p,
    output logic rise_p,
    output logic fall_p
);
    logic scl_q;
    logic sda_q;

    // History starts idle-high so reset never yields a condition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign start_p = scl & scl_q & sda_q & ~sda;
    assign stop_p  = scl & scl_q & ~sda_q & sda;
    assign rise_p  = scl & ~scl_q;
    assign fall_p  = ~scl & scl_q;
endmodule

// File: rtl/hsd_bit_shift.sv
module hsd_bit_shift #(
    parameter int W     = 8,
    parameter int TAG_W = 5,
    parameter logic [TAG_W-1:0] TAG = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rise,
    input  logic bit_in,
    output logic byte_done,
    output logic tag_hit
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

    // Only W-1 bits are kept: the final bit is never part of the tag
    logic [W-2:0]     shreg;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (rise && cnt != FULL) begin
            shreg <= {shreg[W-3:0], bit_in};
            cnt   <= cnt + 1'b1;
        end
    end

    assign byte_done = rise && (cnt == LAST);
    assign tag_hit   = byte_done && (shreg[W-2:W-1-TAG_W] == TAG);
endmodule

// File: rtl/hs_code_detect.sv
module hs_code_detect
    import hsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic hs_mode,
    output logic ack_block
);
    logic start_p, stop_p, rise_p, fall_p;
    logic byte_done, tag_hit;
    hsd_state_e state_q, state_d;
    logic hs_d;

    hsd_cond_det u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (scl_in),
        .sda     (sda_in),
        .start_p (start_p),
        .stop_p  (stop_p),
        .rise_p  (rise_p),
        .fall_p  (fall_p)
    );

    hsd_bit_shift #(
        .W     (BYTE_W),
        .TAG_W (TAG_W),
        .TAG   (HS_TAG)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_p),
        .rise      (rise_p),
        .bit_in    (sda_in),
        .byte_done (byte_done),
        .tag_hit   (tag_hit)
    );

    // Next-state and mode decision
    always_comb begin
        state_d = state_q;
        hs_d    = hs_mode;
        if (stop_p) begin
            state_d = ST_IDLE;
            hs_d    = 1'b0;
        end else if (start_p) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR: begin
                    if (byte_done) begin
                        if (tag_hit && !hs_mode) begin
                            state_d = ST_CODE_ACK;
                            hs_d    = 1'b1;
                        end else begin
                            state_d = ST_PASS;
                        end
                    end
                end
                ST_CODE_ACK: if (rise_p) state_d = ST_CODE_END;
                ST_CODE_END: if (fall_p) state_d = ST_PASS;
                ST_PASS:     state_d = ST_PASS;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hs_mode <= 1'b0;
        end else begin
            state_q <= state_d;
            hs_mode <= hs_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_CODE_ACK, ST_CODE_END: ack_block = 1'b1;
            default:                  ack_block = 1'b0;
        endcase
    end
endmodule

// File: rtl/hsd_chk.sv
module hsd_chk (
    input logic clk,
    input logic rst_n,
    input logic scl,
    input logic sda,
    input logic hs_mode,
    input logic ack_block
);
    // R1: reset forces both outputs low
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!hs_mode && !ack_block));

    // R3: entering high-speed mode opens the no-ack window
    a_r3_rise_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> ack_block);

    // R5: the no-ack window exists only inside high-speed mode
    a_r5_block_in_hs: assert property (@(posedge clk) disable iff (!rst_n)
        ack_block |-> hs_mode);

    // R7: repeated START keeps the mode
    a_r7_rstart_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_mode && scl && $past(scl) && $past(sda) && !sda) |=> hs_mode);

    // R8: STOP clears everything
    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (scl && $past(scl) && !$past(sda) && sda) |=> (!hs_mode && !ack_block));
endmodule

bind hs_code_detect hsd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl       (scl_in),
    .sda       (sda_in),
    .hs_mode   (hs_mode),
    .ack_block (ack_block)
);

// File: tb/sim_hs_code_detect.sv
module sim_hs_code_detect;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic hs_mode, ack_block;
    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    hs_code_detect u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl),
        .sda_in    (sda),
        .hs_mode   (hs_mode),
        .ack_block (ack_block)
    );

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        @(negedge clk);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic bus_start();
        scl = 1'b1; sda = 1'b1; hold(4);
        sda = 1'b0; hold(4);
    endtask

    task automatic bus_rstart();
        scl = 1'b0; hold(2);
        sda = 1'b1; hold(2);
        scl = 1'b1; hold(4);
        sda = 1'b0; hold(4);
    endtask

    task automatic bus_stop();
        scl = 1'b0; hold(2);
        sda = 1'b0; hold(2);
        scl = 1'b1; hold(4);
        sda = 1'b1; hold(4);
    endtask

    task automatic send_bit(input logic b);
        scl = 1'b0; hold(2);
        sda = b;    hold(2);
        scl = 1'b1; hold(4);
    endtask

    // Sends 8 bits plus a released ninth clock; reports ack_block in it and after
    task automatic send_byte(input logic [7:0] b, output logic ack9, output logic ack_after);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        scl = 1'b0; hold(2);
        sda = 1'b1; hold(2);
        scl = 1'b1; hold(4);
        @(negedge clk); ack9 = ack_block;
        hold(1);
        scl = 1'b0; hold(4);
        @(negedge clk); ack_after = ack_block;
        hold(1);
    endtask

    task automatic t_reset();
        check("R1 hs_mode", hs_mode, 1'b0);
        check("R1 ack_block", ack_block, 1'b0);
    endtask

    task automatic t_no_start();
        logic a9, aa;
        send_byte(8'h08, a9, aa);
        check("R2 no start hs", hs_mode, 1'b0);
        check("R2 no start ack", a9, 1'b0);
        bus_stop();
    endtask

    task automatic t_code_then_hs();
        logic a9, aa;
        bus_start();
        send_byte(8'h08, a9, aa);
        check("R5 ack slot", a9, 1'b1);
        check("R3 hs set", hs_mode, 1'b1);
        check("R5 ack released", aa, 1'b0);
        bus_rstart();
        check("R7 rstart keeps", hs_mode, 1'b1);
        send_byte(8'hA0, a9, aa);
        check("R7 addr no block", a9, 1'b0);
        check("R7 hs held", hs_mode, 1'b1);
        bus_stop();
        check("R8 stop clears", hs_mode, 1'b0);
    endtask

    task automatic t_low_bits();
        logic a9, aa;
        for (int x = 0; x < 8; x++) begin
            bus_start();
            send_byte(8'h08 | 8'(x), a9, aa);
            check("R4 low bits", hs_mode, 1'b1);
            check("R4 ack", a9, 1'b1);
            bus_stop();
            check("R8 clear", hs_mode, 1'b0);
        end
    endtask

    task automatic t_normal();
        logic a9, aa;
        logic [7:0] codes [4] = '{8'h50, 8'h10, 8'h00, 8'h88};
        for (int k = 0; k < 4; k++) begin
            bus_start();
            send_byte(codes[k], a9, aa);
            check("R6 hs unchanged", hs_mode, 1'b0);
            check("R6 no block", a9, 1'b0);
            if (k == 0) begin
                send_byte(8'h0B, a9, aa);
                check("R9 data byte hs", hs_mode, 1'b0);
                check("R9 data byte ack", a9, 1'b0);
            end
            bus_stop();
        end
    endtask

    task automatic t_code_again();
        logic a9, aa;
        bus_start();
        send_byte(8'h09, a9, aa);
        check("R3 hs set", hs_mode, 1'b1);
        bus_rstart();
        send_byte(8'h0A, a9, aa);
        check("R7 second code no block", a9, 1'b0);
        check("R7 hs kept", hs_mode, 1'b1);
        bus_stop();
        check("R8 stop clears", hs_mode, 1'b0);
    endtask

    task automatic t_stop_in_ack();
        bus_start();
        for (int i = 7; i >= 0; i--) send_bit(8'h0F >> i);
        scl = 1'b0; hold(2);
        check("R5 block after byte", ack_block, 1'b1);
        sda = 1'b0; hold(2);
        scl = 1'b1; hold(4);
        check("R5 block in ninth", ack_block, 1'b1);
        sda = 1'b1; hold(1);
        check("R8 stop in slot hs", hs_mode, 1'b0);
        check("R8 stop in slot ack", ack_block, 1'b0);
        hold(4);
    endtask

    initial begin
        hold(5);
        t_reset();
        rst_n = 1'b1;
        hold(3);
        t_reset();
        t_no_start();
        t_code_then_hs();
        t_low_bits();
        t_normal();
        t_code_again();
        t_stop_in_ack();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule